// File: doc/BRIEF.md
# Register-Mapped Integer Square Root Unit

This block is a small peripheral on a 16-bit halfword bus. It computes the floor of the square root of an unsigned operand. Software loads a 64-bit operand as four halfwords and a control halfword. The low control bit picks the operand width: either the low 32 bits alone or all 64 bits. Every write to the control halfword or to an operand halfword starts the computation again. From that write until the result is stored, a busy flag reads as one.

The root is produced by the classic bit-pair method, two iterations per clock, in an internal engine. The engine finishes well inside the timing window. The 32-bit root is still copied into two result halfwords only when a fixed timer expires, 26 clock edges after the most recent triggering write. The busy flag drops on that same edge. Until then the result halfwords keep their previous contents. Software either polls the busy flag or simply waits the known latency.

Top module: `isqrt_mmio`

## Requirements
- R1: After reset the busy flag (control bit 15) reads 0, the width bit (control bit 0) reads 0, and both result halfwords read 0.
- R2: A write to the control halfword (address 0) or to any operand halfword (addresses 1 to 4, least significant first) makes the busy flag read 1 on the following cycle.
- R3: With no further triggering write, the busy flag stays 1 for exactly 26 clock edges after the triggering edge. It drops, and the new result appears, on the 26th edge.
- R4: A triggering write while busy restarts the 26-edge window from that write. Completion of the earlier window is cancelled.
- R5: With control bit 0 clear, the upper operand halfwords (addresses 3 and 4) have no effect on the result.
- R6: With control bit 0 set, all 64 operand bits are used.
- R7: The result is floor(sqrt(operand)): 0 gives 0, 2^62 gives 0x80000000, 2^64-1 gives 0xFFFFFFFF, and (2^32-1)^2-1 gives 0xFFFFFFFE. The result is read little-endian, with the low halfword at address 5 and the high halfword at address 6.
- R8: The result halfwords keep their previous value while a computation is pending.
- R9: Writes to the result addresses (5, 6) or to unused addresses change no state and do not set the busy flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Halfword write strobe |
| wr_addr | input | 3 | Halfword write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Halfword read address |
| rd_data | output | 16 | Read data (combinational from rd_addr) |

## Verification
The hardest case to reach is a rewrite that arrives partway through a pending window. The timer must then restart from the later write. The result halfwords must keep the old root for the whole extended span, even though the engine has already produced a different value. The stimulus loads an operand, rewrites one halfword ten cycles later, and the reference model, updated every clock, flags any early busy release or early result change. Back-to-back loads of five halfwords also keep the unit busy across several restarts before each result is committed.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;
  localparam int HALF_W        = 16;
  localparam int CTRL_WIDE_BIT = 0;
  localparam int CTRL_BUSY_BIT = 15;
  localparam int ADDR_CTRL     = 0;
  localparam int ADDR_OP_BASE  = 1;
endpackage

// File: rtl/isqrt_rst_sync.sv
module isqrt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/isqrt_step.sv
module isqrt_step #(
  parameter int W = 64
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] trial_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] trial_o
);
  logic [W-1:0] sum;

  always_comb begin
    sum     = acc_i + trial_i;
    rem_o   = rem_i;
    acc_o   = acc_i;
    trial_o = trial_i >> 2;
    if (trial_i != '0) begin
      if (rem_i >= sum) begin
        rem_o = rem_i - sum;
        acc_o = (acc_i >> 1) + trial_i;
      end else begin
        acc_o = acc_i >> 1;
      end
    end
  end
endmodule

// File: rtl/isqrt_engine.sv
module isqrt_engine #(
  parameter int W     = 64,
  parameter int STEPS = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   operand,
  output logic           done,
  output logic [W/2-1:0] root
);
  localparam logic [W-1:0] TRIAL_TOP = {2'b01, {(W-2){1'b0}}};

  logic [W-1:0] rem_q, acc_q, trial_q;
  logic [W-1:0] rem_d, acc_d, trial_d;
  logic [W-1:0] rem_c   [STEPS+1];
  logic [W-1:0] acc_c   [STEPS+1];
  logic [W-1:0] trial_c [STEPS+1];
  logic         adv_en;

  assign rem_c[0]   = rem_q;
  assign acc_c[0]   = acc_q;
  assign trial_c[0] = trial_q;

  for (genvar s = 0; s < STEPS; s++) begin : g_step
    isqrt_step #(.W(W)) u_step (
      .rem_i   (rem_c[s]),
      .acc_i   (acc_c[s]),
      .trial_i (trial_c[s]),
      .rem_o   (rem_c[s+1]),
      .acc_o   (acc_c[s+1]),
      .trial_o (trial_c[s+1])
    );
  end

  assign done   = (trial_q == '0);
  assign adv_en = start || !done;

  always_comb begin
    if (start) begin
      rem_d   = operand;
      acc_d   = '0;
      trial_d = TRIAL_TOP;
    end else begin
      rem_d   = rem_c[STEPS];
      acc_d   = acc_c[STEPS];
      trial_d = trial_c[STEPS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q   <= '0;
      acc_q   <= '0;
      trial_q <= '0;
    end else if (adv_en) begin
      rem_q   <= rem_d;
      acc_q   <= acc_d;
      trial_q <= trial_d;
    end
  end

  assign root = acc_q[W/2-1:0];

  // R7: while iterating, the remainder never grows
  p_rem_shrinks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !done) |=> (rem_q <= $past(rem_q)));
endmodule

// File: rtl/isqrt_timer.sv
module isqrt_timer #(
  parameter int LAT = 26
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic busy,
  output logic commit
);
  localparam int CW = (LAT > 2) ? $clog2(LAT) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(LAT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          cnt_en;

  assign commit = busy_q && (cnt_q == '0) && !restart;
  assign cnt_en = restart || busy_q;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (restart) begin
      cnt_d  = CNT_LOAD;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;

  // R3: the countdown stays inside its window
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= CNT_LOAD));
  // R3: a commit ends the busy period
  p_commit_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy_q);
  // R4: a restart keeps the unit busy with a full window
  p_restart_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (busy_q && cnt_q == CNT_LOAD));
endmodule

// File: rtl/isqrt_mmio.sv
module isqrt_mmio #(
  parameter int OP_W            = 64,
  parameter int LATENCY         = 26,
  parameter int STEPS_PER_CYCLE = 2,
  parameter int ADDR_W          = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [15:0]       rd_data
);
  import isqrt_pkg::*;

  localparam int RES_W       = OP_W / 2;
  localparam int OP_HW       = OP_W / HALF_W;
  localparam int RES_HW      = RES_W / HALF_W;
  localparam int ADDR_RES_BASE = ADDR_OP_BASE + OP_HW;

  logic                rst_n_i;
  logic                wide_q, wide_d;
  logic [HALF_W-1:0]   op_q [OP_HW];
  logic [HALF_W-1:0]   op_d [OP_HW];
  logic [OP_HW-1:0]    op_we;
  logic [RES_W-1:0]    result_q, result_d;
  logic [OP_W-1:0]     op_full_d, op_eff_d;
  logic                ctrl_we, trig;
  logic                busy, commit;
  logic                eng_done;
  logic [RES_W-1:0]    eng_root;
  logic                res_addr_hit;

  isqrt_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  // write decode
  always_comb begin
    ctrl_we = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
    for (int i = 0; i < OP_HW; i++) begin
      op_we[i] = wr_en && (wr_addr == ADDR_W'(ADDR_OP_BASE + i));
    end
    trig = ctrl_we || (op_we != '0);
    res_addr_hit = 1'b0;
    for (int j = 0; j < RES_HW; j++) begin
      if (wr_addr == ADDR_W'(ADDR_RES_BASE + j)) res_addr_hit = 1'b1;
    end
  end

  // next-state of the software-visible operand and width bit
  always_comb begin
    wide_d = ctrl_we ? wr_data[CTRL_WIDE_BIT] : wide_q;
    for (int i = 0; i < OP_HW; i++) begin
      op_d[i] = op_we[i] ? wr_data : op_q[i];
      op_full_d[HALF_W*i +: HALF_W] = op_d[i];
    end
    if (wide_d) op_eff_d = op_full_d;
    else        op_eff_d = {{(OP_W-RES_W){1'b0}}, op_full_d[RES_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)     wide_q <= 1'b0;
    else if (ctrl_we) wide_q <= wide_d;
  end

  for (genvar g = 0; g < OP_HW; g++) begin : g_op
    always_ff @(posedge clk or negedge rst_n_i) begin
      if (!rst_n_i)      op_q[g] <= '0;
      else if (op_we[g]) op_q[g] <= op_d[g];
    end
  end

  isqrt_engine #(.W(OP_W), .STEPS(STEPS_PER_CYCLE)) u_engine (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .start   (trig),
    .operand (op_eff_d),
    .done    (eng_done),
    .root    (eng_root)
  );

  isqrt_timer #(.LAT(LATENCY)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .restart (trig),
    .busy    (busy),
    .commit  (commit)
  );

  assign result_d = eng_root;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)    result_q <= '0;
    else if (commit) result_q <= result_d;
  end

  // read mux
  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(ADDR_CTRL)) begin
      rd_data[CTRL_WIDE_BIT] = wide_q;
      rd_data[CTRL_BUSY_BIT] = busy;
    end
    for (int i = 0; i < OP_HW; i++) begin
      if (rd_addr == ADDR_W'(ADDR_OP_BASE + i)) rd_data = op_q[i];
    end
    for (int j = 0; j < RES_HW; j++) begin
      if (rd_addr == ADDR_W'(ADDR_RES_BASE + j)) rd_data = result_q[HALF_W*j +: HALF_W];
    end
  end

  // R2: a triggering write raises busy on the next cycle
  p_busy_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n_i)
    trig |=> busy);
  // R7: the engine has settled by the time its root is committed
  p_root_ready_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
    commit |-> eng_done);
  // R8: result halfwords move only on a commit
  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n_i)
    !commit |=> $stable(result_q));
  // R9: a write to a result address while idle leaves the unit idle
  p_res_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n_i)
    (wr_en && res_addr_hit && !busy) |=> !busy);
endmodule

// File: tb/isqrt_mmio_bench.sv
`timescale 1ns/100ps
module isqrt_mmio_bench;
  localparam int LAT = 26;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  isqrt_mmio u_isqrt_mmio (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #4 clk = ~clk;

  // reference model state
  logic [15:0] m_op [4];
  logic        m_wide;
  logic        m_busy;
  int          m_left;
  logic [31:0] m_res;

  function automatic logic [31:0] ref_root(input logic [63:0] x);
    logic [31:0] r;
    logic [31:0] t;
    r = '0;
    for (int i = 31; i >= 0; i--) begin
      t = r | (32'd1 << i);
      if ({32'd0, t} * {32'd0, t} <= x) r = t;
    end
    return r;
  endfunction

  function automatic logic [63:0] m_operand();
    logic [63:0] v;
    v = {m_op[3], m_op[2], m_op[1], m_op[0]};
    if (!m_wide) v[63:32] = '0;
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // model update and per-cycle comparison
  always @(posedge clk) begin
    logic [15:0] c, lo, hi;
    logic trig;
    cyc++;
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_op[i] = '0;
      m_wide = 0; m_busy = 0; m_left = 0; m_res = '0;
    end else begin
      trig = wr_en && (wr_addr <= 3'd4);
      if (wr_en && wr_addr == 3'd0) m_wide = wr_data[0];
      if (wr_en && wr_addr >= 3'd1 && wr_addr <= 3'd4) m_op[wr_addr-1] = wr_data;
      if (trig) begin
        m_busy = 1; m_left = LAT;
      end else if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0;
          m_res = ref_root(m_operand());
        end
      end
    end
    #0.5 rd_addr = 3'd0; #0.5 c = rd_data;
    rd_addr = 3'd5; #0.5 lo = rd_data;
    rd_addr = 3'd6; #0.5 hi = rd_data;
    if (rst_n) begin
      chk("R3 busy per cycle", {31'd0, c[15]}, {31'd0, m_busy});
      chk("R7/R8 result per cycle", {hi, lo}, m_res);
    end
    if (cyc > 60000) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    #0.5 rd_addr = a; #0.5 d = rd_data;
  endtask

  task automatic rd_result(output logic [31:0] r);
    logic [15:0] lo, hi;
    rd(3'd5, lo); rd(3'd6, hi);
    r = {hi, lo};
  endtask

  task automatic load(input logic [63:0] v, input logic wide);
    for (int i = 0; i < 4; i++) wr(3'(i + 1), v[16*i +: 16]);
    wr(3'd0, {15'd0, wide});
  endtask

  task automatic run_case(input string tag, input logic [63:0] v, input logic wide,
                          input logic [31:0] exp);
    logic [31:0] r;
    load(v, wide);
    wait_n(LAT + 2);
    rd_result(r);
    chk(tag, r, exp);
  endtask

  initial begin
    logic [15:0] c;
    logic [31:0] r, prev;
    wait_n(3);
    rst_n = 1;
    wait_n(4);
    // R1 reset state
    rd(3'd0, c);
    chk("R1 ctrl after reset", {16'd0, c}, 32'd0);
    rd_result(r);
    chk("R1 result after reset", r, 32'd0);

    run_case("R7 zero", 64'd0, 1'b1, 32'd0);
    run_case("R7 one", 64'd1, 1'b0, 32'd1);
    run_case("R7 fifteen", 64'd15, 1'b0, 32'd3);
    run_case("R7 sixteen", 64'd16, 1'b0, 32'd4);
    run_case("R7 2^62", 64'h4000_0000_0000_0000, 1'b1, 32'h8000_0000);
    run_case("R7 all ones", 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 32'hFFFF_FFFF);
    run_case("R7 square minus one", 64'hFFFF_FFFE_0000_0000, 1'b1, 32'hFFFF_FFFE);
    run_case("R5 narrow ignores upper", 64'hDEAD_BEEF_0000_0010, 1'b0, 32'd4);
    run_case("R5 narrow all ones", 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 32'h0000_FFFF);
    run_case("R6 wide uses upper", 64'h0000_0001_0000_0000, 1'b1, 32'h0001_0000);
    rd(3'd0, c);
    chk("R6 width bit readback", {31'd0, c[0]}, 32'd1);

    // R2 busy immediately after a single halfword write
    wr(3'd2, 16'h0003);
    rd(3'd0, c);
    chk("R2 busy after write", {31'd0, c[15]}, 32'd1);
    wait_n(LAT + 2);

    // R4 restart mid-window, R8 hold of the previous result
    rd_result(prev);
    load(64'd1_000_000, 1'b0);
    wait_n(10);
    wr(3'd1, 16'd0);            // restarts; operand now 983040
    wait_n(LAT - 12);           // past the first window's end
    rd(3'd0, c);
    chk("R4 still busy after restart", {31'd0, c[15]}, 32'd1);
    rd_result(r);
    chk("R8 result held while pending", r, prev);
    wait_n(14);
    rd(3'd0, c);
    chk("R4 idle after restarted window", {31'd0, c[15]}, 32'd0);
    rd_result(r);
    chk("R4 root of rewritten operand", r, ref_root(64'd983040));

    // R9 writes to result and unused addresses
    prev = r;
    wr(3'd5, 16'h1234);
    wr(3'd6, 16'h5678);
    wr(3'd7, 16'hFFFF);
    rd(3'd0, c);
    chk("R9 no busy from result write", {31'd0, c[15]}, 32'd0);
    rd_result(r);
    chk("R9 result unchanged", r, prev);

    // back-to-back random operands, checked by the per-cycle model
    for (int k = 0; k < 40; k++) begin
      logic [63:0] v;
      v = {$urandom, $urandom};
      if (k % 4 == 0) v = v >> ($urandom % 64);
      load(v, 1'(k % 2));
      wait_n(LAT + 2);
      rd_result(r);
      chk("R7 random root", r, ref_root((k % 2 == 1) ? v : {32'd0, v[31:0]}));
    end
    finish_run();
  end
endmodule